// File: doc/BRIEF.md
# DMA Channel Enable and Completion Control

This block is the control and status logic of a single DMA channel. It keeps a channel enable, a transfer-done flag, an interrupt enable and a down-counter holding the number of transfers still to run. Each cycle it decides whether the channel may move data and, if so, issues a one-cycle transfer strobe to the datapath. When the last programmed transfer goes out, it raises the done flag and, if enabled, a level interrupt.

Software uses a small register port. Register 0 holds the control bits and register 1 holds the remaining count. A run is started by loading the count and then setting the enable bit. Transfers can be held off by the controller-wide master enable, an NMI flag or an address-error flag. In auto mode the channel paces itself. In external mode each new request edge gives one transfer. A run can be paused and later resumed from where it stopped. The done flag stays set until software reads it as 1 and then writes 0 to it.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, chanEn, xferDone, xferStrobe and irq are 0, and both registers read back as 0.
- R2: xferStrobe is 0 unless chanEn=1, xferDone=0, masterEn=1, nmiFlag=0, addrErr=0 and the remaining count is nonzero.
- R3: With autoMode=1, xferStrobe is 1 in every cycle where the conditions of R2 hold, in that same cycle.
- R4: With autoMode=0, xferStrobe is 1 only in a cycle where extReq is 1 after being 0 in the previous cycle and the R2 conditions hold. A request held high since before enabling gives no strobe.
- R5: Register 1 (regAddr=1) holds the remaining count. A write loads it, each strobe lowers it by one, and it keeps its value while the channel is stopped, so re-enabling resumes the run.
- R6: The strobe that takes the count from 1 to 0 sets xferDone at that clock edge. xferDone reads back as bit 1 of register 0 (regAddr=0); bit 0 is the enable and bit 2 is the interrupt enable.
- R7: A run that stops before the count reaches 0 (enable cleared, master enable low, NMI or address error) leaves xferDone at 0.
- R8: While xferDone=1, no strobe is issued, even with chanEn=1 and a nonzero count.
- R9: xferDone clears only on a write to register 0 with bit 1 = 0 that follows a read of register 0 returning bit 1 = 1, with no register-0 write in between. Writing 1 to bit 1 has no effect.
- R10: irq equals xferDone AND the interrupt enable, as a level.
- R11: A cycle with standby=1 clears chanEn and xferDone at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby entry, clears enable and done |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 = control, 1 = count |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, combinational |
| autoMode | input | 1 | 1 = auto request, 0 = external request |
| extReq | input | 1 | External or peripheral request |
| masterEn | input | 1 | Controller-wide enable |
| nmiFlag | input | 1 | Controller NMI flag, blocks transfers |
| addrErr | input | 1 | Controller address-error flag, blocks transfers |
| xferStrobe | output | 1 | One transfer this cycle |
| chanEn | output | 1 | Channel enable bit |
| xferDone | output | 1 | Transfer-done flag |
| irq | output | 1 | Completion interrupt level |

## Verification
xferStrobe, irq and regRdData are combinational from the current state and inputs. They are due in the same cycle as the stimulus. chanEn, xferDone and the count change at the clock edge that ends a write or strobe cycle, so their effect shows one cycle later. The bench drives every input at the falling edge and samples 1 ns later, before the next rising edge. Register effects are therefore always checked in the cycle after the one that caused them, and strobes in the cycle itself.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;
  localparam int EN_BIT   = 0;
  localparam int DONE_BIT = 1;
  localparam int IE_BIT   = 2;
  localparam int CTRL_W   = 3;

  typedef struct packed {
    logic load;
    logic dec;
  } cntCmd_t;
endpackage

// File: rtl/dmac_count.sv
module dmac_count
  import dmac_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             nonZero,
  output logic             lastOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (cmd.load) count <= loadVal;
    else if (cmd.dec) count <= count - ONE;
  end

  assign nonZero = (count != '0);
  assign lastOne = (count == ONE);
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regAddr,
  input  logic [CTRL_W-1:0] ctrlWrBits,
  input  logic              autoMode,
  input  logic              extReq,
  input  logic              masterEn,
  input  logic              nmiFlag,
  input  logic              addrErr,
  input  logic              cntNonZero,
  input  logic              cntLastOne,
  output cntCmd_t           cmd,
  output logic              xferStrobe,
  output logic              chanEn,
  output logic              xferDone,
  output logic              ieBit,
  output logic              irq
);
  logic ctrlWr, ctrlRd, readSeen, extPrev, permit, reqOk, finish;

  assign ctrlWr   = regWrEn && (regAddr == ADDR_CTRL);
  assign ctrlRd   = regRdEn && (regAddr == ADDR_CTRL);
  assign cmd.load = regWrEn && (regAddr == ADDR_CNT);

  assign permit = chanEn && !xferDone && masterEn && !nmiFlag && !addrErr && cntNonZero;
  assign reqOk  = autoMode ? 1'b1 : (extReq && !extPrev);
  assign xferStrobe = permit && reqOk;
  assign cmd.dec    = xferStrobe && !cmd.load;
  assign finish     = cmd.dec && cntLastOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanEn   <= 1'b0;
      xferDone <= 1'b0;
      ieBit    <= 1'b0;
      readSeen <= 1'b0;
      extPrev  <= 1'b0;
    end else begin
      extPrev <= extReq;
      if (standby) begin
        chanEn   <= 1'b0;
        xferDone <= 1'b0;
        readSeen <= 1'b0;
      end else begin
        if (ctrlWr) begin
          chanEn   <= ctrlWrBits[EN_BIT];
          ieBit    <= ctrlWrBits[IE_BIT];
          readSeen <= 1'b0;
        end else if (ctrlRd && xferDone) begin
          readSeen <= 1'b1;
        end
        if (finish) xferDone <= 1'b1;
        else if (ctrlWr && readSeen && !ctrlWrBits[DONE_BIT]) xferDone <= 1'b0;
      end
    end
  end

  assign irq = xferDone && ieBit;
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dmac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              autoMode,
  input  logic              extReq,
  input  logic              masterEn,
  input  logic              nmiFlag,
  input  logic              addrErr,
  output logic              xferStrobe,
  output logic              chanEn,
  output logic              xferDone,
  output logic              irq
);
  cntCmd_t          cmd;
  logic [CNT_W-1:0] count;
  logic             nonZero, lastOne, ieBit;

  dmac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .ctrlWrBits(regWrData[CTRL_W-1:0]),
    .autoMode(autoMode), .extReq(extReq), .masterEn(masterEn),
    .nmiFlag(nmiFlag), .addrErr(addrErr),
    .cntNonZero(nonZero), .cntLastOne(lastOne),
    .cmd(cmd), .xferStrobe(xferStrobe), .chanEn(chanEn),
    .xferDone(xferDone), .ieBit(ieBit), .irq(irq)
  );

  dmac_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .loadVal(regWrData[CNT_W-1:0]),
    .count(count), .nonZero(nonZero), .lastOne(lastOne)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) begin
      regRdData[EN_BIT]   = chanEn;
      regRdData[DONE_BIT] = xferDone;
      regRdData[IE_BIT]   = ieBit;
    end else begin
      regRdData[CNT_W-1:0] = count;
    end
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk (
  input logic clk,
  input logic rstN,
  input logic standby,
  input logic regWrEn,
  input logic regAddr,
  input logic wrDoneBit,
  input logic masterEn,
  input logic nmiFlag,
  input logic addrErr,
  input logic xferStrobe,
  input logic chanEn,
  input logic xferDone,
  input logic irq
);
  // R2
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStrobe |-> (chanEn && !xferDone && masterEn && !nmiFlag && !addrErr));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDone) |-> $past(xferStrobe));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !standby && !(regWrEn && !regAddr && !wrDoneBit)) |=> xferDone);

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> xferDone);

  // R11
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!chanEn && !xferDone));
endmodule

bind dma_chan_ctl dmac_chk u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .regWrEn(regWrEn),
  .regAddr(regAddr), .wrDoneBit(regWrData[1]), .masterEn(masterEn),
  .nmiFlag(nmiFlag), .addrErr(addrErr), .xferStrobe(xferStrobe),
  .chanEn(chanEn), .xferDone(xferDone), .irq(irq)
);

// File: tb/tb_dma_chan_ctl.sv
module tb_dma_chan_ctl;
  logic clk = 1'b0, rstN = 1'b0, standby = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic autoMode = 1'b1, extReq = 1'b0, masterEn = 1'b1, nmiFlag = 1'b0, addrErr = 1'b0;
  logic xferStrobe, chanEn, xferDone, irq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  dma_chan_ctl dut (.*);

  typedef struct packed {
    logic wr; logic rd; logic addr; logic [7:0] data;
    logic eStb; logic eDone; logic eIrq;
  } vec_t;

  // auto mode, master enable on; one row per cycle
  localparam vec_t TABLE [10] = '{
    '{1'b1, 1'b0, 1'b1, 8'd3, 1'b0, 1'b0, 1'b0},  // load count 3
    '{1'b1, 1'b0, 1'b0, 8'd5, 1'b0, 1'b0, 1'b0},  // enable + ie
    '{1'b0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 1'b0},  // R3 strobe
    '{1'b0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 1'b0},  // last transfer
    '{1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1, 1'b1},  // R6 done, R10 irq
    '{1'b1, 1'b0, 1'b0, 8'd5, 1'b0, 1'b1, 1'b1},  // R9 write 0 w/o read
    '{1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 1'b1},  // R9 read as 1
    '{1'b1, 1'b0, 1'b0, 8'd5, 1'b0, 1'b1, 1'b1},  // R9 write 0 clears
    '{1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0}   // R9 cleared
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic a, input logic [7:0] d,
                      input logic au, input logic ex, input logic me,
                      input logic nm, input logic ae, input logic sb);
    @(negedge clk);
    regWrEn = w; regRdEn = r; regAddr = a; regWrData = d;
    autoMode = au; extReq = ex; masterEn = me; nmiFlag = nm; addrErr = ae; standby = sb;
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1 strobe", xferStrobe, 0); chk("R1 en", chanEn, 0);
    chk("R1 done", xferDone, 0); chk("R1 irq", irq, 0);
    chk("R1 ctrl rd", regRdData, 0);
    regAddr = 1'b1; #1;
    chk("R1 cnt rd", regRdData, 0);
    regAddr = 1'b0;
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < 10; i++) begin
      step(TABLE[i].wr, TABLE[i].rd, TABLE[i].addr, TABLE[i].data, 1, 0, 1, 0, 0, 0);
      chk($sformatf("R3/R6/R9/R10 row%0d strobe", i), xferStrobe, TABLE[i].eStb);
      chk($sformatf("R6/R9 row%0d done", i), xferDone, TABLE[i].eDone);
      chk($sformatf("R10 row%0d irq", i), irq, TABLE[i].eIrq);
    end

    // gating by controller flags: R2
    step(1, 0, 1, 8'd5, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 8'd0, 1, 0, 0, 0, 0, 0);
    chk("R2 masterEn low", xferStrobe, 0); chk("R5 loaded", regRdData, 5);
    step(0, 0, 0, 8'd0, 1, 0, 1, 1, 0, 0); chk("R2 nmi", xferStrobe, 0);
    step(0, 0, 0, 8'd0, 1, 0, 1, 0, 1, 0); chk("R2 addrErr", xferStrobe, 0);
    step(0, 0, 0, 8'd0, 1, 0, 1, 0, 0, 0); chk("R3 go", xferStrobe, 1);
    step(0, 0, 0, 8'd0, 1, 0, 1, 0, 0, 0); chk("R3 go2", xferStrobe, 1);
    step(1, 0, 0, 8'd4, 1, 0, 1, 0, 0, 0); chk("R3 last before stop", xferStrobe, 1);
    // suspended: R5, R7
    step(0, 0, 1, 8'd0, 1, 0, 1, 0, 0, 0);
    chk("R2 disabled", xferStrobe, 0); chk("R5 held", regRdData, 2);
    chk("R7 no done on stop", xferDone, 0);
    step(0, 0, 1, 8'd0, 1, 0, 1, 0, 0, 0); chk("R5 still held", regRdData, 2);
    step(1, 0, 0, 8'd5, 1, 0, 1, 0, 0, 0); chk("R5 pre-resume", xferStrobe, 0);
    step(0, 0, 0, 8'd0, 1, 0, 1, 0, 0, 0); chk("R5 resume", xferStrobe, 1);
    step(0, 0, 0, 8'd0, 1, 0, 1, 0, 0, 0); chk("R5 resume last", xferStrobe, 1);
    step(0, 0, 0, 8'd0, 1, 0, 1, 0, 0, 0);
    chk("R6 done", xferDone, 1); chk("R10 irq", irq, 1);
    chk("R6 rd bit1", regRdData[1], 1);
    // R8: done blocks even with count reloaded
    step(1, 0, 1, 8'd4, 1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 8'd0, 1, 0, 1, 0, 0, 0); chk("R8 blocked", xferStrobe, 0);
    // R9 writing 1 no effect, R10 ie off drops irq
    step(1, 0, 0, 8'd3, 1, 0, 1, 0, 0, 0);
    step(0, 1, 0, 8'd0, 1, 0, 1, 0, 0, 0);
    chk("R9 write1 no effect", xferDone, 1); chk("R10 irq off", irq, 0);
    step(1, 0, 0, 8'd1, 1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 8'd0, 1, 0, 1, 0, 0, 0);
    chk("R9 cleared", xferDone, 0); chk("R8 runs again", xferStrobe, 1);
    // R4 external request edges
    step(0, 0, 0, 8'd0, 0, 0, 1, 0, 0, 0); chk("R4 no req", xferStrobe, 0);
    step(0, 0, 0, 8'd0, 0, 1, 1, 0, 0, 0); chk("R4 rising", xferStrobe, 1);
    step(0, 0, 0, 8'd0, 0, 1, 1, 0, 0, 0); chk("R4 held", xferStrobe, 0);
    step(0, 0, 0, 8'd0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 8'd0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 8'd0, 0, 1, 1, 0, 0, 0); chk("R4 disabled req", xferStrobe, 0);
    step(1, 0, 0, 8'd1, 0, 1, 1, 0, 0, 0);
    step(0, 0, 1, 8'd0, 0, 1, 1, 0, 0, 0);
    chk("R4 old req ignored", xferStrobe, 0); chk("R5 count", regRdData, 2);
    step(0, 0, 0, 8'd0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 8'd0, 0, 1, 1, 0, 0, 0); chk("R4 new req", xferStrobe, 1);
    step(0, 0, 0, 8'd0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 8'd0, 0, 1, 1, 0, 0, 0); chk("R4 final req", xferStrobe, 1);
    step(0, 0, 0, 8'd0, 0, 0, 1, 0, 0, 0); chk("R6 ext done", xferDone, 1);
    // R11 standby
    step(0, 0, 0, 8'd0, 0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 8'd0, 0, 0, 1, 0, 0, 0);
    chk("R11 en cleared", chanEn, 0); chk("R11 done cleared", xferDone, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule